// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. It holds an accumulator and a status byte. Each cycle in which an operation is offered, it combines the accumulator with a second operand from the temporary operand register. The operation is add, add with carry-in, subtract, subtract with borrow-in, AND, OR, XOR, compare, increment, decrement, or load.

The result goes back into the accumulator. Compare is the exception: it only updates the status byte. The status byte holds five condition bits at fixed positions: sign, zero, nibble carry, even parity and carry. The unused positions read as zero.

Both outputs are registered. The effect of an operation is visible on the cycle after the clock edge that accepts it. Instruction decoding and register-file selection happen upstream of this block.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_q` becomes 0 and `flags_q` becomes 0.
- R2: The status byte is laid out as sign at bit 7, zero at bit 6, nibble carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R3: Opcode 0 (add) writes A+B to the accumulator. Opcode 1 (add with carry) writes A+B+CY. In both, carry is set exactly when the sum exceeds 255.
- R4: Opcode 2 (subtract) writes A-B modulo 256 and sets carry exactly when B > A. Opcode 3 (subtract with borrow) writes A-B-CY modulo 256 and sets carry exactly when B+CY > A.
- R5: For arithmetic operations, nibble carry is the carry out of bit 3 of the adder. The adder computes the following:
  - add: A+B
  - add with carry: A+B+CY
  - subtract and compare: A+~B+1
  - subtract with borrow: A+~B+!CY
  - increment: A+1
  - decrement: A+0xFF
- R6: Every flag-updating operation sets sign to bit 7 of its result. It sets zero when the result is 0x00. It sets parity when the result has an even number of ones.
- R7: Opcode 7 (compare) sets all five flags exactly as subtract would and leaves the accumulator unchanged.
- R8: Opcodes 4 (AND), 5 (OR) and 6 (XOR) write the bitwise result and clear carry. AND sets nibble carry; OR and XOR clear it.
- R9: Opcode 8 (increment) writes A+1 and opcode 9 (decrement) writes A-1, both modulo 256. Both leave carry unchanged.
- R10: Opcode 10 (load) copies the operand into the accumulator and leaves the status byte unchanged.
- R11: When `op_valid` is low, or the opcode is 11 to 15, the accumulator and status byte keep their values.
- R12: An operation accepted at a clock edge is reflected in `acc_q` and `flags_q` immediately after that same edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 4 | Operation select, encodings as in R3 to R11 |
| operand | input | DATA_W | Second operand (temporary register) |
| acc_q | output | DATA_W | Accumulator |
| flags_q | output | 8 | Status byte |

## Verification
Two functions can meet in one operation: the carry-in taken from the status byte, and the new carry the same operation writes back. Add with carry, subtract with borrow, increment and decrement all read or keep the old carry while producing a new status byte. The bench first sets carry with a directed add, then issues these operations back to back, and then runs a long random stream where every opcode follows every other. On every clock, a behavioural model that tracks its own accumulator and carry judges the whole accumulator and status byte.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int FLAG_W = 8;
  localparam int NIB_W  = 4;

  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_CARRY = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_LOAD = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {SRC_B, SRC_NOT_B, SRC_ZERO, SRC_ONES} opnd_sel_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_CY, CIN_NCY} cin_sel_e;
  typedef enum logic [2:0] {RES_SUM, RES_AND, RES_OR, RES_XOR, RES_PASS} res_sel_e;
  typedef enum logic [1:0] {CYM_CARRY, CYM_BORROW, CYM_KEEP, CYM_CLEAR} cy_mode_e;
  typedef enum logic [1:0] {ACM_NIB, ACM_SET, ACM_CLEAR} ac_mode_e;

  typedef struct packed {
    logic      legal;
    logic      wr_acc;
    logic      upd_flags;
    opnd_sel_e osel;
    cin_sel_e  csel;
    res_sel_e  rsel;
    cy_mode_e  cymode;
    ac_mode_e  acmode;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_flag_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{legal: 1'b1, wr_acc: 1'b1, upd_flags: 1'b1,
             osel: SRC_B, csel: CIN_ZERO, rsel: RES_SUM,
             cymode: CYM_CARRY, acmode: ACM_NIB};
    case (op_code)
      OP_ADD: ;
      OP_ADC: ctrl.csel = CIN_CY;
      OP_SUB: begin
        ctrl.osel   = SRC_NOT_B;
        ctrl.csel   = CIN_ONE;
        ctrl.cymode = CYM_BORROW;
      end
      OP_SBB: begin
        ctrl.osel   = SRC_NOT_B;
        ctrl.csel   = CIN_NCY;
        ctrl.cymode = CYM_BORROW;
      end
      OP_CMP: begin
        ctrl.osel   = SRC_NOT_B;
        ctrl.csel   = CIN_ONE;
        ctrl.cymode = CYM_BORROW;
        ctrl.wr_acc = 1'b0;
      end
      OP_AND: begin
        ctrl.rsel   = RES_AND;
        ctrl.cymode = CYM_CLEAR;
        ctrl.acmode = ACM_SET;
      end
      OP_OR: begin
        ctrl.rsel   = RES_OR;
        ctrl.cymode = CYM_CLEAR;
        ctrl.acmode = ACM_CLEAR;
      end
      OP_XOR: begin
        ctrl.rsel   = RES_XOR;
        ctrl.cymode = CYM_CLEAR;
        ctrl.acmode = ACM_CLEAR;
      end
      OP_INC: begin
        ctrl.osel   = SRC_ZERO;
        ctrl.csel   = CIN_ONE;
        ctrl.cymode = CYM_KEEP;
      end
      OP_DEC: begin
        ctrl.osel   = SRC_ONES;
        ctrl.cymode = CYM_KEEP;
      end
      OP_LOAD: begin
        ctrl.rsel      = RES_PASS;
        ctrl.upd_flags = 1'b0;
      end
      default: begin
        ctrl.legal     = 1'b0;
        ctrl.wr_acc    = 1'b0;
        ctrl.upd_flags = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cy_in,
  input  alu_ctrl_t         ctrl,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              nib_carry
);

  localparam int SUM_W = DATA_W + 1;
  localparam int NSUM_W = NIB_W + 1;

  logic [DATA_W-1:0] x_opnd;
  logic              cin;
  logic [SUM_W-1:0]  sum;
  logic [NSUM_W-1:0] nib_sum;

  always_comb begin
    case (ctrl.osel)
      SRC_B:     x_opnd = opnd;
      SRC_NOT_B: x_opnd = ~opnd;
      SRC_ZERO:  x_opnd = '0;
      default:   x_opnd = '1;
    endcase
    case (ctrl.csel)
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_CY:   cin = cy_in;
      default:  cin = ~cy_in;
    endcase
  end

  assign sum     = {1'b0, acc} + {1'b0, x_opnd} + {{DATA_W{1'b0}}, cin};
  assign nib_sum = {1'b0, acc[NIB_W-1:0]} + {1'b0, x_opnd[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};

  assign carry_out = sum[DATA_W];
  assign nib_carry = nib_sum[NIB_W];

  always_comb begin
    case (ctrl.rsel)
      RES_SUM: result = sum[DATA_W-1:0];
      RES_AND: result = acc & opnd;
      RES_OR:  result = acc | opnd;
      RES_XOR: result = acc ^ opnd;
      default: result = opnd;
    endcase
  end

endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  input  logic              nib_carry,
  input  logic              cy_old,
  input  alu_ctrl_t         ctrl,
  output logic [FLAG_W-1:0] flags_next
);

  logic cy_new;
  logic ac_new;

  always_comb begin
    case (ctrl.cymode)
      CYM_CARRY:  cy_new = carry_out;
      CYM_BORROW: cy_new = ~carry_out;
      CYM_KEEP:   cy_new = cy_old;
      default:    cy_new = 1'b0;
    endcase
    case (ctrl.acmode)
      ACM_NIB: ac_new = nib_carry;
      ACM_SET: ac_new = 1'b1;
      default: ac_new = 1'b0;
    endcase
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (i == FB_SIGN) begin : g_s
      assign flags_next[i] = result[DATA_W-1];
    end else if (i == FB_ZERO) begin : g_z
      assign flags_next[i] = ~|result;
    end else if (i == FB_HALF) begin : g_ac
      assign flags_next[i] = ac_new;
    end else if (i == FB_PAR) begin : g_p
      assign flags_next[i] = ~^result;
    end else if (i == FB_CARRY) begin : g_cy
      assign flags_next[i] = cy_new;
    end else begin : g_fill
      assign flags_next[i] = 1'b0;
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_q,
  output logic [7:0]        flags_q
);

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] result;
  logic              carry_out;
  logic              nib_carry;
  logic [FLAG_W-1:0] flags_next;

  alu_op_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  alu_arith_core #(.DATA_W(DATA_W)) u_core (
    .acc       (acc_q),
    .opnd      (operand),
    .cy_in     (flags_q[FB_CARRY]),
    .ctrl      (ctrl),
    .result    (result),
    .carry_out (carry_out),
    .nib_carry (nib_carry)
  );

  alu_flag_pack #(.DATA_W(DATA_W)) u_pack (
    .result     (result),
    .carry_out  (carry_out),
    .nib_carry  (nib_carry),
    .cy_old     (flags_q[FB_CARRY]),
    .ctrl       (ctrl),
    .flags_next (flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (op_valid && ctrl.legal) begin
      if (ctrl.wr_acc)    acc_q   <= result;
      if (ctrl.upd_flags) flags_q <= flags_next;
    end
  end

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] acc_q,
  input logic [7:0]        flags_q
);

  logic writes_result;
  logic is_logic;
  logic is_incdec;
  logic is_dead;
  assign writes_result = op_valid && (op_code <= 4'd9) && (op_code != 4'd7);
  assign is_logic  = op_valid && (op_code >= 4'd4) && (op_code <= 4'd6);
  assign is_incdec = op_valid && (op_code == 4'd8 || op_code == 4'd9);
  assign is_dead   = !op_valid || (op_code > 4'd10);

  AST_FILLER_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags_q[5] == 1'b0 && flags_q[3] == 1'b0 && flags_q[1] == 1'b0); // R2

  AST_SIGN_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    writes_result |=> flags_q[7] == acc_q[DATA_W-1]); // R6

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    writes_result |=> flags_q[6] == (acc_q == '0)); // R6

  AST_PARITY_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    writes_result |=> flags_q[2] == ~^acc_q); // R6

  AST_COMPARE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7) |=> $stable(acc_q)); // R7

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> flags_q[0] == 1'b0); // R8

  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    is_incdec |=> $stable(flags_q[0])); // R9

  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd10) |=> $stable(flags_q)); // R10

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    is_dead |=> ($stable(acc_q) && $stable(flags_q))); // R11

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .acc_q    (acc_q),
  .flags_q  (flags_q)
);

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] operand;
  logic [7:0] acc_q;
  logic [7:0] flags_q;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  int m_flags = 0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  alu_flag_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc_q(acc_q), .flags_q(flags_q)
  );

  function automatic string tag_of(input logic v, input int op);
    if (!v || op > 10) return "R11";
    case (op)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4, 5, 6: return "R8";
      7:       return "R7";
      8, 9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  task automatic compare_all();
    check($sformatf("%s R12 accumulator", last_tag), acc_q, m_acc);
    check($sformatf("%s R5 R6 R12 flags", last_tag), flags_q, m_flags);
    check("R2 filler bits", flags_q & 8'h2A, 0);
  endtask

  task automatic model(input logic v, input int op, input int b);
    int a, c, r, cy, ac, s, p;
    a = m_acc; c = m_flags & 1; cy = c; ac = 0; r = a;
    if (!v || op > 10) return;
    case (op)
      0: begin s = a + b;     r = s & 255; cy = s > 255; ac = ((a & 15) + (b & 15)) > 15; end
      1: begin s = a + b + c; r = s & 255; cy = s > 255; ac = ((a & 15) + (b & 15) + c) > 15; end
      2, 7: begin r = (a - b) & 255; cy = b > a; ac = ((a & 15) + (15 - (b & 15)) + 1) > 15; end
      3: begin r = (a - b - c) & 255; cy = (b + c) > a; ac = ((a & 15) + (15 - (b & 15)) + (1 - c)) > 15; end
      4: begin r = a & b; cy = 0; ac = 1; end
      5: begin r = a | b; cy = 0; ac = 0; end
      6: begin r = a ^ b; cy = 0; ac = 0; end
      8: begin r = (a + 1) & 255; ac = (a & 15) == 15; end
      9: begin r = (a + 255) & 255; ac = (a & 15) != 0; end
      default: begin m_acc = b; return; end
    endcase
    p = ($countones(r) % 2 == 0) ? 1 : 0;
    m_flags = (((r >> 7) & 1) << 7) | ((r == 0 ? 1 : 0) << 6) | (ac << 4) | (p << 2) | cy;
    if (op != 7) m_acc = r;
  endtask

  task automatic step(input logic v, input int op, input int b);
    @(negedge clk);
    compare_all();
    op_valid = v; op_code = op[3:0]; operand = b[7:0];
    model(v, op, b);
    last_tag = tag_of(v, op);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b1; op_code = 4'd0; operand = 8'h55;
    repeat (3) @(negedge clk);
    check("R1 reset accumulator", acc_q, 0);
    check("R1 reset flags", flags_q, 0);
    rst = 1'b0; op_valid = 1'b0;
    // R10 load, then R3/R5 nibble carry without carry
    step(1, 10, 8'h0F);
    step(1, 0, 8'h01);
    // R3 overflow to zero: Z, AC, CY, P all set
    step(1, 10, 8'hFF);
    step(1, 0, 8'h01);
    // carry consumed by add-with-carry, subtract-with-borrow in sequence
    step(1, 1, 8'h10);
    step(1, 2, 8'h20);
    step(1, 3, 8'h00);
    // R9 inc/dec keep CY; dec from zero wraps
    step(1, 10, 8'h00);
    step(1, 9, 8'h00);
    step(1, 8, 8'h00);
    // R7 compare equal and greater
    step(1, 7, 8'h00);
    step(1, 7, 8'hFF);
    // R8 logic ops
    step(1, 4, 8'h0F);
    step(1, 5, 8'hA0);
    step(1, 6, 8'hFF);
    // R11 invalid and illegal opcodes
    step(0, 0, 8'h33);
    step(1, 12, 8'h33);
    step(1, 15, 8'h77);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 15);
      step(($urandom_range(0, 7) != 0), op, $urandom_range(0, 255));
    end
    step(0, 0, 0);
    @(negedge clk);
    compare_all();
    summary();
    $finish;
  end

endmodule